// File: doc/BRIEF.md
# Late-Write Pipelined Memory with Byte-Lane Forwarding

This block is a synchronous single-port memory. Every operation is taken on the rising clock edge. A write presents its address, its global write strobe and its per-lane enables in one cycle. The matching write data follows one cycle later. The block holds the whole write (address, lane mask and data) in a pending-write buffer. It copies that buffer into the internal array only when the next accepted write arrives, and any number of reads may fall in between.

Reads return their word one cycle after the address is sampled. If a read address matches the buffered address, each lane the buffered write enabled comes from the buffer and every other lane comes from the array. The latency is the same on a hit as on a miss. If the read lands in the very cycle the buffer is capturing its data, the data arriving on the input in that cycle is forwarded.

The read port has a drive flag and a read data word. The word is forced to zero whenever the flag is low, which stands in for a high-impedance bus. Two asynchronous inputs can force the output off: an output enable and a power-down input. Power-down also makes the block ignore commands and keeps the memory contents. After power-down is released, commands are ignored for a fixed number of wake cycles.

Top module: `late_write_sram`

## Requirements
- R1: A read (selN low, wrN high) accepted at a rising edge sets rdDrive high and shows the read word on rdData for the following cycle.
- R2: A write accepted at one edge takes its data from wrData at the next edge. The array is updated only when the next accepted write arrives, so reads of other addresses in between see the old array contents.
- R3: A read whose address equals the buffered write address returns, in each lane the buffered write enabled, the buffered data, and array data in the other lanes.
- R4: A read accepted at the same edge where the buffer captures its write data, and hitting the buffered address, forwards the wrData value present at that edge.
- R5: The word is four 9-bit lanes; laneWrN bit i (active low) controls rdData/wrData bits [9i+8:9i]. A write with all laneWrN bits high changes no array byte.
- R6: After any edge where selN is high or wrN is low, rdDrive is low for the next cycle, and rdData is all zeros whenever rdDrive is low.
- R7: oeN high forces rdDrive low at once without a clock edge; the last read word is shown again when oeN returns low.
- R8: While sleep is high, rdDrive is low, commands are ignored and the memory contents (array and buffer) are kept.
- R9: For WAKE_CYC rising edges after sleep is released, commands are ignored; the command at the next edge is accepted.
- R10: After reset, rdDrive is low and the buffer is empty, so a read of any address returns array data (all zeros after reset) until a write has been accepted.
- R11: Back-to-back reads of the same address with no write between them keep rdData unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low reset |
| addr | input | ADDR_W | Word address, sampled with the command |
| selN | input | 1 | Active-low select |
| wrN | input | 1 | Active-low global write |
| laneWrN | input | LANES | Active-low per-lane write enables |
| wrData | input | LANES*LANE_W | Write data, one cycle after its write command |
| oeN | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Power-down request, active high |
| rdData | output | LANES*LANE_W | Read word, zero when not driven |
| rdDrive | output | 1 | High when rdData is being driven |

## Verification
Assertions check four things on every cycle: the drive flag drops after write or deselect edges, the asynchronous output-enable and power-down cut-offs, zero data while undriven, and a stable word across same-address read pairs. The late commit, lane-wise merging on a buffer hit, forwarding in the capture cycle, and commands ignored during power-down and wake-up change only data values. Only the bench's scenarios can show those, by comparing against its behavioural model, which tracks the array, the pending write and the wake counter.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  // strobes handed from control to datapath for one clock edge
  typedef struct packed {
    logic doRead;   // accepted read command
    logic doWrite;  // accepted write command (captures address and mask)
    logic capture;  // wrData belongs to the previous write, latch it
    logic commit;   // copy the pending buffer into the array
    logic fwdOk;    // buffer holds a write address
    logic fwdLive;  // buffer data not captured yet, use wrData
  } strobe_t;
endpackage

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
  import lwsram_pkg::*;
#(
  parameter int WAKE_CYC = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    selN,
  input  logic    wrN,
  input  logic    sleep,
  output strobe_t stb
);
  localparam int CW = $clog2(WAKE_CYC + 1);

  logic [CW-1:0] wakeCnt;
  logic          dataPending;
  logic          bufValid;
  logic          accept;

  assign accept = !sleep && (wakeCnt == '0);

  always_comb begin
    stb         = '0;
    stb.doRead  = accept && !selN && wrN;
    stb.doWrite = accept && !selN && !wrN;
    stb.capture = dataPending;
    stb.commit  = stb.doWrite && bufValid;
    stb.fwdOk   = bufValid;
    stb.fwdLive = dataPending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeCnt     <= '0;
      dataPending <= 1'b0;
      bufValid    <= 1'b0;
    end else begin
      if (sleep)              wakeCnt <= CW'(WAKE_CYC);
      else if (wakeCnt != '0) wakeCnt <= wakeCnt - 1'b1;
      dataPending <= stb.doWrite;
      bufValid    <= bufValid | stb.doWrite;
    end
  end
endmodule

// File: rtl/lwsram_dpath.sv
module lwsram_dpath
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        laneWrN,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    oeN,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdDrive
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] bufAddr;
  logic [LANES-1:0]  bufMask;
  logic [DATA_W-1:0] bufData;
  logic [DATA_W-1:0] effData;
  logic [DATA_W-1:0] arrWord;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rdQ;
  logic              readQ;
  logic              hit;

  assign effData = stb.fwdLive ? wrData : bufData;
  assign arrWord = mem[addr];
  assign hit     = stb.fwdOk && (addr == bufAddr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = (hit && bufMask[g])
                                        ? effData[g*LANE_W +: LANE_W]
                                        : arrWord[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (stb.commit) begin
      for (int l = 0; l < LANES; l++)
        if (bufMask[l]) mem[bufAddr][l*LANE_W +: LANE_W] <= effData[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufAddr <= '0;
      bufMask <= '0;
      bufData <= '0;
      rdQ     <= '0;
      readQ   <= 1'b0;
    end else begin
      if (stb.capture) bufData <= wrData;
      if (stb.doWrite) begin
        bufAddr <= addr;
        bufMask <= ~laneWrN;
      end
      readQ <= stb.doRead;
      if (stb.doRead) rdQ <= merged;
    end
  end

  assign rdDrive = readQ && !oeN && !sleep;
  assign rdData  = rdDrive ? rdQ : '0;
endmodule

// File: rtl/late_write_sram.sv
module late_write_sram
  import lwsram_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int LANES    = 4,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    selN,
  input  logic                    wrN,
  input  logic [LANES-1:0]        laneWrN,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    oeN,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdDrive
);
  strobe_t stb;

  lwsram_ctrl #(.WAKE_CYC(WAKE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .wrN(wrN), .sleep(sleep), .stb(stb)
  );

  lwsram_dpath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .laneWrN(laneWrN),
    .wrData(wrData), .oeN(oeN), .sleep(sleep), .rdData(rdData), .rdDrive(rdDrive)
  );
endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              selN,
  input logic              wrN,
  input logic              oeN,
  input logic              sleep,
  input logic [DATA_W-1:0] rdData,
  input logic              rdDrive
);
  // R6
  no_drive_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selN || !wrN) |=> !rdDrive);
  // R6
  zero_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdDrive |-> (rdData == '0));
  // R7
  oe_cuts_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !rdDrive);
  // R8
  sleep_cuts_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !rdDrive);
  // R11
  same_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdDrive && $past(rdDrive) && ($past(addr, 1) == $past(addr, 2))) |-> $stable(rdData));
endmodule

bind late_write_sram lwsram_chk #(.ADDR_W(ADDR_W), .DATA_W(LANES*LANE_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .selN(selN), .wrN(wrN), .oeN(oeN),
  .sleep(sleep), .rdData(rdData), .rdDrive(rdDrive)
);

// File: tb/late_write_sram_bench.sv
module late_write_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int LANES = 4;
  localparam int LANE_W = 9;
  localparam int WAKE_CYC = 3;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 0, rstN = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic selN = 1, wrN = 1, oeN = 0, sleep = 0;
  logic [LANES-1:0] laneWrN = '1;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic rdDrive;

  late_write_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .WAKE_CYC(WAKE_CYC))
    u_late_write_sram (.clk(clk), .rstN(rstN), .addr(addr), .selN(selN), .wrN(wrN),
      .laneWrN(laneWrN), .wrData(wrData), .oeN(oeN), .sleep(sleep),
      .rdData(rdData), .rdDrive(rdDrive));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  string curReq = "R10";

  // behavioural reference model
  logic [DATA_W-1:0] refMem [DEPTH];
  logic refBufValid = 0, refPend = 0, refRead = 0;
  logic [ADDR_W-1:0] refAddr = '0;
  logic [LANES-1:0] refMask = '0;
  logic [DATA_W-1:0] refData = '0, refQ = '0;
  int refWake = 0;

  task automatic modelEdge();
    logic [DATA_W-1:0] live;
    logic ok;
    live = refPend ? wrData : refData;
    ok = !sleep && refWake == 0;
    if (sleep) refWake = WAKE_CYC; else if (refWake > 0) refWake--;
    refRead = 0;
    if (ok && !selN && wrN) begin
      refQ = refMem[addr];
      if (refBufValid && addr == refAddr)
        for (int l = 0; l < LANES; l++)
          if (refMask[l]) refQ[l*LANE_W +: LANE_W] = live[l*LANE_W +: LANE_W];
      refRead = 1;
    end
    if (refPend) begin refData = wrData; refPend = 0; end
    if (ok && !selN && !wrN) begin
      if (refBufValid)
        for (int l = 0; l < LANES; l++)
          if (refMask[l]) refMem[refAddr][l*LANE_W +: LANE_W] = live[l*LANE_W +: LANE_W];
      refAddr = addr; refMask = ~laneWrN; refBufValid = 1; refPend = 1;
    end
  endtask

  task automatic compare(string req);
    logic expDrv;
    logic [DATA_W-1:0] expDat;
    expDrv = refRead && !oeN && !sleep;
    expDat = expDrv ? refQ : '0;
    total++;
    if (rdDrive !== expDrv || rdData !== expDat) begin
      bad++;
      $display("FAIL %s t=%0t drive=%b data=%h expected drive=%b data=%h",
               req, $time, rdDrive, rdData, expDrv, expDat);
    end
  endtask

  task automatic expectWord(string req, logic expDrv, logic [DATA_W-1:0] expDat);
    total++;
    if (rdDrive !== expDrv || rdData !== expDat) begin
      bad++;
      $display("FAIL %s t=%0t drive=%b data=%h expected drive=%b data=%h",
               req, $time, rdDrive, rdData, expDrv, expDat);
    end
  endtask

  // inputs set at negedge, edge taken, model advanced, outputs checked at next negedge
  task automatic step(input logic s, input logic w, input logic [ADDR_W-1:0] a,
                      input logic [LANES-1:0] ln, input logic [DATA_W-1:0] d);
    selN = s; wrN = w; addr = a; laneWrN = ln; wrData = d;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compare(curReq);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d = '0);
    step(0, 1, a, '1, d);
  endtask
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] ln,
                    input logic [DATA_W-1:0] d = '0);
    step(0, 0, a, ln, d);
  endtask
  task automatic nop(input logic [DATA_W-1:0] d = '0);
    step(1, 1, '0, '1, d);
  endtask

  localparam logic [DATA_W-1:0] X1 = 36'h1_2345_6789;
  localparam logic [DATA_W-1:0] Y1 = 36'hA_BCDE_F012;

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    expectWord("R10", 1'b0, '0);
    rstN = 1;
    curReq = "R10";
    rd(0);
    expectWord("R10", 1'b1, '0);
    nop();

    // R1/R4: write then read in data phase
    curReq = "R4";
    wr(5, 4'b0000);
    rd(5, X1);
    expectWord("R4", 1'b1, X1);
    // R2: other address sees the old array
    curReq = "R2";
    rd(7);
    expectWord("R2", 1'b1, '0);
    // R3: read hit from the buffer
    curReq = "R3";
    rd(5);
    expectWord("R3", 1'b1, X1);
    // R5 partial write of lanes 0 and 2 to address 5 (commits X1)
    curReq = "R5";
    wr(5, 4'b1010);
    nop(Y1);
    rd(5);
    expectWord("R3", 1'b1, {X1[35:27], Y1[26:18], X1[17:9], Y1[8:0]});
    // R5: all lanes disabled writes nothing
    wr(9, 4'b1111);
    nop(Y1);
    wr(10, 4'b0000);
    nop(X1);
    rd(9);
    expectWord("R5", 1'b1, '0);
    rd(5);
    expectWord("R2", 1'b1, {X1[35:27], Y1[26:18], X1[17:9], Y1[8:0]});
    // R11: back-to-back same address
    curReq = "R11";
    rd(10); rd(10); rd(10);
    expectWord("R11", 1'b1, X1);
    // R7: async output enable
    curReq = "R7";
    #1 oeN = 1; #1;
    expectWord("R7", 1'b0, '0);
    rd(10);
    oeN = 0; #1;
    expectWord("R7", 1'b1, X1);
    // R6: deselect and write edges
    curReq = "R6";
    nop();
    expectWord("R6", 1'b0, '0);
    wr(11, 4'b0000);
    expectWord("R6", 1'b0, '0);
    nop(Y1);
    // R8: sleep, commands ignored
    curReq = "R8";
    sleep = 1;
    wr(12, 4'b0000); nop(X1); rd(11);
    expectWord("R8", 1'b0, '0);
    sleep = 0;
    // R9: wake window
    curReq = "R9";
    for (int k = 0; k < WAKE_CYC; k++) wr(11, 4'b0000, '0);
    rd(11);
    expectWord("R9", 1'b1, Y1);
    rd(12);
    expectWord("R8", 1'b1, '0);

    // R1/R2: random mix against the model
    curReq = "R1";
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 99);
      oeN = ($urandom_range(0, 19) == 0);
      sleep = ($urandom_range(0, 49) == 0);
      if (r < 45) rd($urandom_range(0, 7), {$urandom, $urandom});
      else if (r < 85) wr($urandom_range(0, 7), 4'($urandom), {$urandom, $urandom});
      else nop({$urandom, $urandom});
    end
    oeN = 0; sleep = 0;
    for (int k = 0; k < WAKE_CYC + 1; k++) nop();
    curReq = "R2";
    for (int a = 0; a < 8; a++) rd(a);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule